// File: doc/BRIEF.md
# Memory Board Bank Enable Controller

This block is the control logic of a memory board that covers a 64K address space as four 16K banks. On every memory cycle it splits the 16-bit bus address into a bank index. It then decides whether the board answers, using a write-only control register that software loads through an I/O port, and it drives a one-hot bank select for the array.

The control port also carries a sticky parity-error flag. The flag is set by the parity checker during a memory read that the board serves, and software reads it back on the same port. A static 3-bit strap routes the flag to exactly one of eight CPU response lines: five vectored interrupts, a maskable interrupt, a non-maskable interrupt, or a ready line that is pulled low to stall the CPU.

A mode strap selects how the register is used. In per-bank mode each register bit switches one bank off. In code mode the board answers only while the whole register equals a build-time code. Build-time variants with two or three banks never answer in the missing upper ranges.

Top module: `mbc_top`

## Requirements
- R1: The bank index is addr[15:14] (0: 0000-3FFF, 1: 4000-7FFF, 2: 8000-BFFF, 3: C000-FFFF). While board_sel is high, bank_sel is one-hot with bit index equal to that bank index. Otherwise bank_sel is zero.
- R2: In per-bank mode (bank_mode=0), control bit n equal to 1 keeps the board from answering in bank n, and bit n equal to 0 lets it answer there. board_sel is high only while mem_req is high.
- R3: In per-bank mode with all four control bits 0, the board answers at every address from 0000 to FFFF.
- R4: Synchronous reset sets all four control bits to 1, so the board is deselected in both modes. It also clears the parity flag, drives all response outputs low and drives rdy_o high.
- R5: A control write happens when io_wr is high and addr[7:0] equals CTRL_PORT (default 8'h40). It loads wr_data[3:0] at the clock edge, and the new value takes effect from the next cycle. A write strobe at any other port address leaves the control bits unchanged.
- R6: While io_rd is high and addr[7:0] equals CTRL_PORT, rd_data is {7'b0, parity flag}. rd_data is 8'h00 at any other time.
- R7: The parity flag sets on the clock edge after parity_err is seen together with mem_req, mem_rd and board_sel all high. parity_err has no effect outside such a served memory read.
- R8: Once set, the parity flag stays set until reset or until a control-port write clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: While the flag is set, resp_sel picks exactly one active response: 0-4 drive vi[0]-vi[4] high, 5 drives int_o high, 6 drives nmi_o high, and 7 drives rdy_o low. All other response outputs stay inactive.
- R10: In code mode (bank_mode=1), the board answers in any present bank only while the control register equals BANK_CODE (default 4'b0001).
- R11: With NUM_BANKS below 4, the board never answers at addresses in banks NUM_BANKS to 3, whatever the mode or control bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on clear) |
| bank_mode | input | 1 | Strap: 0 per-bank disable, 1 code match |
| resp_sel | input | 3 | Strap: parity error response line select |
| addr | input | 16 | Bus address; low byte is also the I/O port number |
| mem_req | input | 1 | Memory cycle in progress |
| mem_rd | input | 1 | Memory cycle is a read |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| wr_data | input | 8 | I/O write data |
| parity_err | input | 1 | Parity mismatch from the checker |
| rd_data | output | 8 | I/O read data |
| board_sel | output | 1 | Board answers the current memory cycle |
| bank_sel | output | 4 | One-hot selected bank |
| vi | output | 5 | Vectored interrupt requests |
| int_o | output | 1 | Maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |
| rdy_o | output | 1 | Ready; low stalls the CPU |

## Verification
The bench builds two copies that share every input. One uses the defaults (four banks, port 8'h40, code 4'b0001). The other has NUM_BANKS=3 and models the 48K build. Running them side by side puts the suppressed top range within reach of the same vectors that show the full board answering there. The shared default code lets code-mode vectors show both a match and a mismatch.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    localparam int ADDR_W    = 16;
    localparam int BANK_BITS = 2;
    localparam int MAX_BANKS = 1 << BANK_BITS;
    localparam int DATA_W    = 8;
    localparam int VI_LINES  = 5;

    typedef enum logic [2:0] {
        RESP_VI1   = 3'd0,
        RESP_VI2   = 3'd1,
        RESP_VI3   = 3'd2,
        RESP_VI4   = 3'd3,
        RESP_VI5   = 3'd4,
        RESP_INT   = 3'd5,
        RESP_NMI   = 3'd6,
        RESP_STALL = 3'd7
    } resp_e;

    typedef struct packed {
        logic                 present;
        logic [BANK_BITS-1:0] idx;
    } bank_hit_t;

    function automatic logic [MAX_BANKS-1:0] idx_onehot(input logic [BANK_BITS-1:0] i);
        logic [MAX_BANKS-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/mbc_addr_decode.sv
module mbc_addr_decode
    import mbc_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output bank_hit_t         hit
);
    logic [MAX_BANKS-1:0] present_mask;

    genvar g;
    generate
        for (g = 0; g < MAX_BANKS; g++) begin : g_present
            assign present_mask[g] = (g < NUM_BANKS) ? 1'b1 : 1'b0;
        end
    endgenerate

    always_comb begin
        hit.idx     = addr[ADDR_W-1 -: BANK_BITS];
        hit.present = present_mask[hit.idx];
    end

endmodule

// File: rtl/mbc_ctrl_reg.sv
module mbc_ctrl_reg
    import mbc_pkg::*;
#(
    parameter logic [7:0] CTRL_PORT = 8'h40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 io_wr,
    input  logic [7:0]           port_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [MAX_BANKS-1:0] ctrl_q,
    output logic                 ctrl_wr
);
    assign ctrl_wr = io_wr && (port_addr == CTRL_PORT);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '1;
        else if (ctrl_wr)
            ctrl_q <= wr_data[MAX_BANKS-1:0];
    end

    // R5: the register moves only on a decoded write
    a_r5_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(ctrl_q));

    // R4: power-on clear leaves every bank disabled
    a_r4_ctrl_reset: assert property (@(posedge clk)
        rst |=> (ctrl_q == '1));

endmodule

// File: rtl/mbc_parity_resp.sv
module mbc_parity_resp
    import mbc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                set_evt,
    input  logic                clr_evt,
    input  resp_e               resp_sel,
    output logic                flag_q,
    output logic [VI_LINES-1:0] vi,
    output logic                int_o,
    output logic                nmi_o,
    output logic                rdy_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_evt)
            flag_q <= 1'b1;
        else if (clr_evt)
            flag_q <= 1'b0;
    end

    genvar g;
    generate
        for (g = 0; g < VI_LINES; g++) begin : g_vi
            assign vi[g] = flag_q && (resp_sel == resp_e'(g));
        end
    endgenerate

    assign int_o = flag_q && (resp_sel == RESP_INT);
    assign nmi_o = flag_q && (resp_sel == RESP_NMI);
    assign rdy_o = !(flag_q && (resp_sel == RESP_STALL));

    // R8: flag is sticky until cleared
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_evt) |=> flag_q);

    // R9: never more than one response line active
    a_r9_one_line: assert property (@(posedge clk) disable iff (rst)
        $countones({vi, int_o, nmi_o, !rdy_o}) <= 1);

    // R9: a set flag always reaches exactly one line
    a_r9_flag_routed: assert property (@(posedge clk) disable iff (rst)
        flag_q |-> ($countones({vi, int_o, nmi_o, !rdy_o}) == 1));

    // R4: reset leaves every response line quiet
    a_r4_resp_reset: assert property (@(posedge clk)
        rst |=> (!flag_q && rdy_o && (vi == '0) && !int_o && !nmi_o));

endmodule

// File: rtl/mbc_top.sv
module mbc_top
    import mbc_pkg::*;
#(
    parameter int         NUM_BANKS = 4,
    parameter logic [7:0] CTRL_PORT = 8'h40,
    parameter logic [3:0] BANK_CODE = 4'b0001
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bank_mode,
    input  logic [2:0]           resp_sel,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 mem_req,
    input  logic                 mem_rd,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 parity_err,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 board_sel,
    output logic [MAX_BANKS-1:0] bank_sel,
    output logic [VI_LINES-1:0]  vi,
    output logic                 int_o,
    output logic                 nmi_o,
    output logic                 rdy_o
);
    bank_hit_t            hit;
    logic [MAX_BANKS-1:0] ctrl_q;
    logic                 ctrl_wr;
    logic                 enable;
    logic                 flag_q;
    logic                 set_evt;

    mbc_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (addr),
        .hit  (hit)
    );

    mbc_ctrl_reg #(.CTRL_PORT(CTRL_PORT)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .io_wr     (io_wr),
        .port_addr (addr[7:0]),
        .wr_data   (wr_data),
        .ctrl_q    (ctrl_q),
        .ctrl_wr   (ctrl_wr)
    );

    always_comb begin
        if (bank_mode)
            enable = (ctrl_q == BANK_CODE);
        else
            enable = !ctrl_q[hit.idx];
    end

    assign board_sel = mem_req && hit.present && enable;
    assign bank_sel  = board_sel ? idx_onehot(hit.idx) : '0;
    assign set_evt   = parity_err && mem_req && mem_rd && board_sel;

    mbc_parity_resp u_par (
        .clk      (clk),
        .rst      (rst),
        .set_evt  (set_evt),
        .clr_evt  (ctrl_wr),
        .resp_sel (resp_e'(resp_sel)),
        .flag_q   (flag_q),
        .vi       (vi),
        .int_o    (int_o),
        .nmi_o    (nmi_o),
        .rdy_o    (rdy_o)
    );

    assign rd_data = (io_rd && (addr[7:0] == CTRL_PORT)) ? {7'b0, flag_q} : '0;

    // R1: at most one bank line at a time
    a_r1_bank_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_sel));

    // R2: a disabled bank is never answered in per-bank mode
    a_r2_disabled_bank: assert property (@(posedge clk) disable iff (rst)
        (!bank_mode && ctrl_q[addr[15:14]]) |-> !board_sel);

    // R7: the flag rises only after a served read with a parity error
    a_r7_flag_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(parity_err && mem_req && mem_rd && board_sel));

    // R11: absent upper banks never answer
    a_r11_absent_bank: assert property (@(posedge clk) disable iff (rst)
        (int'(addr[15:14]) >= NUM_BANKS) |-> !board_sel);

endmodule

// File: tb/mbc_top_tb.sv
module mbc_top_tb;

    typedef struct packed {
        logic        mode;
        logic [3:0]  ctrl;
        logic [15:0] addr;
        logic        exp4;
        logic        exp3;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'b0000, 16'h0000, 1'b1, 1'b1},  // R3
        '{1'b0, 4'b0000, 16'hFFFF, 1'b1, 1'b0},  // R3 R11
        '{1'b0, 4'b0001, 16'h1234, 1'b0, 1'b0},  // R2
        '{1'b0, 4'b0001, 16'h4000, 1'b1, 1'b1},  // R2
        '{1'b0, 4'b0010, 16'h7FFF, 1'b0, 1'b0},  // R2
        '{1'b0, 4'b0100, 16'hBFFF, 1'b0, 1'b0},  // R2
        '{1'b0, 4'b0100, 16'hC000, 1'b1, 1'b0},  // R2 R11
        '{1'b0, 4'b1000, 16'hC000, 1'b0, 1'b0},  // R2
        '{1'b0, 4'b1000, 16'h8000, 1'b1, 1'b1},  // R2
        '{1'b0, 4'b1111, 16'h4000, 1'b0, 1'b0},  // R2
        '{1'b1, 4'b0001, 16'h0000, 1'b1, 1'b1},  // R10
        '{1'b1, 4'b0001, 16'hE000, 1'b1, 1'b0},  // R10 R11
        '{1'b1, 4'b0000, 16'h4000, 1'b0, 1'b0},  // R10
        '{1'b1, 4'b1110, 16'h8000, 1'b0, 1'b0}   // R10
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bank_mode;
    logic [2:0]  resp_sel;
    logic [15:0] addr;
    logic        mem_req, mem_rd, io_wr, io_rd, parity_err;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data, rd_data3;
    logic        board_sel, board_sel3;
    logic [3:0]  bank_sel, bank_sel3;
    logic [4:0]  vi, vi3;
    logic        int_o, nmi_o, rdy_o, int3, nmi3, rdy3;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mbc_top u_dut (
        .clk(clk), .rst(rst), .bank_mode(bank_mode), .resp_sel(resp_sel),
        .addr(addr), .mem_req(mem_req), .mem_rd(mem_rd), .io_wr(io_wr),
        .io_rd(io_rd), .wr_data(wr_data), .parity_err(parity_err),
        .rd_data(rd_data), .board_sel(board_sel), .bank_sel(bank_sel),
        .vi(vi), .int_o(int_o), .nmi_o(nmi_o), .rdy_o(rdy_o)
    );

    mbc_top #(.NUM_BANKS(3)) u_dut48 (
        .clk(clk), .rst(rst), .bank_mode(bank_mode), .resp_sel(resp_sel),
        .addr(addr), .mem_req(mem_req), .mem_rd(mem_rd), .io_wr(io_wr),
        .io_rd(io_rd), .wr_data(wr_data), .parity_err(parity_err),
        .rd_data(rd_data3), .board_sel(board_sel3), .bank_sel(bank_sel3),
        .vi(vi3), .int_o(int3), .nmi_o(nmi3), .rdy_o(rdy3)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ctrl_write(input logic [7:0] port, input logic [7:0] data);
        @(negedge clk);
        addr    = {8'h00, port};
        wr_data = data;
        io_wr   = 1'b1;
        @(negedge clk);
        io_wr   = 1'b0;
    endtask

    task automatic flag_read(output logic f);
        addr  = 16'h0040;
        io_rd = 1'b1;
        #1;
        f = rd_data[0];
        io_rd = 1'b0;
    endtask

    task automatic mem_cycle(input logic [15:0] a, input logic rd, input logic perr);
        @(negedge clk);
        addr = a; mem_req = 1'b1; mem_rd = rd; parity_err = perr;
        @(negedge clk);
        mem_req = 1'b0; mem_rd = 1'b0; parity_err = 1'b0;
    endtask

    function automatic logic [7:0] resp_vec(input logic [2:0] s);
        // {vi[4:0], int, nmi, !rdy}
        case (s)
            3'd5:    return 8'b00000_100;
            3'd6:    return 8'b00000_010;
            3'd7:    return 8'b00000_001;
            default: return {5'(5'b1 << s), 3'b000};
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic f;
        rst = 1'b1; bank_mode = 1'b0; resp_sel = 3'd1; addr = '0;
        mem_req = 0; mem_rd = 0; io_wr = 0; io_rd = 0; parity_err = 0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4: reset state
        mem_req = 1'b1; addr = 16'h0000; #1;
        check("R4 deselected normal", {15'b0, board_sel}, 16'd0);
        bank_mode = 1'b1; #1;
        check("R4 deselected code", {15'b0, board_sel}, 16'd0);
        bank_mode = 1'b0; mem_req = 1'b0;
        check("R4 lines", {8'b0, vi, int_o, nmi_o, !rdy_o}, 16'd0);
        flag_read(f);
        check("R4 R6 flag", {15'b0, f}, 16'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            bank_mode = VECS[i].mode;
            ctrl_write(8'h40, {4'b0, VECS[i].ctrl});
            addr = VECS[i].addr; mem_req = 1'b1; #1;
            check($sformatf("R2 R3 R10 vec%0d", i), {15'b0, board_sel}, {15'b0, VECS[i].exp4});
            check($sformatf("R11 vec%0d", i), {15'b0, board_sel3}, {15'b0, VECS[i].exp3});
            check($sformatf("R1 vec%0d", i), {12'b0, bank_sel},
                  VECS[i].exp4 ? 16'(4'b1 << VECS[i].addr[15:14]) : 16'd0);
            mem_req = 1'b0;
        end
        bank_mode = 1'b0;

        // R2: no memory cycle, no answer
        ctrl_write(8'h40, 8'h00);
        addr = 16'h2000; mem_req = 1'b0; #1;
        check("R2 idle", {15'b0, board_sel}, 16'd0);

        // R5: write to another port ignored
        ctrl_write(8'h41, 8'h0F);
        addr = 16'h2000; mem_req = 1'b1; #1;
        check("R5 other port", {15'b0, board_sel}, 16'd1);
        mem_req = 1'b0;

        // R7: parity error on a write cycle ignored
        mem_cycle(16'h1000, 1'b0, 1'b1);
        flag_read(f);
        check("R7 write ignored", {15'b0, f}, 16'd0);

        // R7: parity error on an unserved read ignored
        ctrl_write(8'h40, 8'h01);
        mem_cycle(16'h0100, 1'b1, 1'b1);
        flag_read(f);
        check("R7 unserved ignored", {15'b0, f}, 16'd0);

        // R7: served read sets flag
        ctrl_write(8'h40, 8'h00);
        resp_sel = 3'd2;
        mem_cycle(16'h8100, 1'b1, 1'b1);
        flag_read(f);
        check("R7 R6 set", {15'b0, f}, 16'd1);
        check("R9 vi3", {8'b0, vi, int_o, nmi_o, !rdy_o}, {8'b0, resp_vec(3'd2)});

        // R6: reads of other ports return zero
        addr = 16'h0042; io_rd = 1'b1; #1;
        check("R6 other port", {8'b0, rd_data}, 16'd0);
        io_rd = 1'b0;

        // R9: every routing choice
        for (int s = 0; s < 8; s++) begin
            resp_sel = 3'(s); #1;
            check($sformatf("R9 sel%0d", s), {8'b0, vi, int_o, nmi_o, !rdy_o}, {8'b0, resp_vec(3'(s))});
        end

        // R8: sticky across idle cycles and foreign writes
        repeat (4) @(negedge clk);
        ctrl_write(8'h41, 8'h00);
        flag_read(f);
        check("R8 sticky", {15'b0, f}, 16'd1);

        // R8: control write clears
        ctrl_write(8'h40, 8'h00);
        flag_read(f);
        check("R8 cleared", {15'b0, f}, 16'd0);
        check("R8 rdy restored", {15'b0, rdy_o}, 16'd1);

        // R8: set wins over simultaneous clear
        @(negedge clk);
        addr = 16'h0040; mem_req = 1'b1; mem_rd = 1'b1; parity_err = 1'b1;
        io_wr = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        mem_req = 0; mem_rd = 0; parity_err = 0; io_wr = 0;
        flag_read(f);
        check("R8 set wins", {15'b0, f}, 16'd1);

        // R4: reset clears everything again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        flag_read(f);
        check("R4 flag after reset", {15'b0, f}, 16'd0);
        addr = 16'h4000; mem_req = 1'b1; #1;
        check("R4 deselected after reset", {15'b0, board_sel}, 16'd0);
        mem_req = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule